// File: doc/BRIEF.md
# Two-Bank SDRAM Command Decoder and Bank Tracker

This block sits at the command input of a two-bank synchronous DRAM. On every rising clock edge it samples clock enable, chip select, the three active-low command strobes and a 12-bit address. From these it works out which command was issued. It keeps, for each bank, whether the bank is open and which row is open. When a read or write asks for it, it closes the bank automatically once the burst is over. It also tracks the low-power state that a low clock enable selects, holds the burst length set by a mode-register load, and raises a flag when a refresh is overdue.

Every output is registered and changes on the edge that samples the command. Address bit 11 picks the bank (0 = bank A, 1 = bank B). Bits 10..0 carry the row on an activate. Bit 10 is also a control flag whose meaning depends on the command: it requests auto-precharge on a read or write, and it selects both banks on a precharge. The data path and the array timing rules are outside this block.

Top module: `sdram_cmd_bank`

## Requirements
- R1: While cs_n is high, no command strobe pulses and no bank is opened or closed by the sampled command. An auto-precharge countdown already running keeps counting and closes its bank on time.
- R2: With cke high and cs_n low, {ras_n,cas_n,we_n} decodes as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh, 000 mode-register load, and 111 or 110 no operation. A legal command pulses exactly one strobe for the one cycle after its edge, and at most one of the seven strobes is ever high.
- R3: An activate to an idle bank opens the bank selected by addr[11] and records addr[10:0] as its open row (row_a for bank A, row_b for bank B).
- R4: An activate to a bank that is already open raises illegal_stb and leaves that bank's row unchanged.
- R5: A read or write to an idle bank raises illegal_stb, pulses neither rd_stb nor wr_stb, and leaves the bank idle.
- R6: A read or write with addr[10] high closes the addressed bank exactly burst_len edges after the command edge. With addr[10] low the bank stays open.
- R7: A precharge with addr[10] high closes both banks. With addr[10] low it closes only the bank that addr[11] selects.
- R8: A mode-register load with both banks idle sets the burst length from addr[2:0]: codes 0, 1, 2 and 3 give 1, 2, 4 and 8, and codes 4 to 7 give 8. If either bank is open, the load is illegal and the burst length is kept. After reset the burst length is 1.
- R9: An auto refresh while either bank is open raises illegal_stb instead of ref_stb.
- R10: On an edge with cke low, no strobe pulses and bank state, rows and countdowns are frozen. pwr_mode then reads 1 (power-down) if both banks are idle and 2 (suspend) if either bank is open.
- R11: An auto refresh sampled with cke low while both banks are idle sets pwr_mode to 3 (self refresh). The mode holds while cke stays low and returns to 0 on the first edge with cke high.
- R12: ref_due rises REF_INTERVAL edges after reset or after the last legal auto refresh, if no further refresh has been issued. A legal auto refresh or self refresh clears it.
- R13: After reset, all strobes are low, both banks are idle, burst_len is 1, pwr_mode is 0 and ref_due is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low gates the internal clock |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Bit 11 bank, bit 10 control flag, bits 10..0 row, bits 2..0 mode code |
| act_stb | output | 1 | Legal activate decoded |
| rd_stb | output | 1 | Legal read decoded |
| wr_stb | output | 1 | Legal write decoded |
| pre_stb | output | 1 | Precharge decoded |
| ref_stb | output | 1 | Legal auto refresh decoded |
| mrs_stb | output | 1 | Legal mode-register load decoded |
| illegal_stb | output | 1 | Command rejected for the current bank state |
| bank_active | output | 2 | Open flag per bank, bit 0 = bank A |
| row_a | output | 11 | Open row of bank A |
| row_b | output | 11 | Open row of bank B |
| burst_len | output | 4 | Current burst length in beats |
| pwr_mode | output | 2 | 0 run, 1 power-down, 2 suspend, 3 self refresh |
| ref_due | output | 1 | Refresh interval has expired |

## Verification
The decoder is driven with each strobe pattern against each combination of open and idle banks. This tells a legal command apart from one that is rejected for the bank state, and checks that an illegal command leaves rows and burst length untouched. Auto-precharge is run with burst lengths 1 and 4, with the clock held by cs_n high and with cke low during the countdown. These cases separate a countdown that keeps running during a deselect from one that freezes under clock gating, and a close on the exact edge from one a cycle early or late. The precharge flag is driven with bit 10 both set and clear against the two bank selects, which distinguishes an all-bank close from a single-bank close. The low-power entries are tried from idle and open banks, with and without a refresh command, which tells power-down, suspend and self refresh apart.

// File: rtl/sdram_cb_pkg.sv
`timescale 1ns/1ps
package sdram_cb_pkg;

    // Decoded command after clock-enable and chip-select gating
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6
    } cmd_e;

    // Low-power state reported on pwr_mode
    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_PDOWN = 2'd1,
        PM_SUSP  = 2'd2,
        PM_SELF  = 2'd3
    } pmode_e;

    // Map the three active-low strobes onto a command
    function automatic cmd_e strobe_to_cmd(input logic ras_n, input logic cas_n, input logic we_n);
        cmd_e c;
        case ({ras_n, cas_n, we_n})
            3'b011:  c = CMD_ACT;
            3'b101:  c = CMD_RD;
            3'b100:  c = CMD_WR;
            3'b010:  c = CMD_PRE;
            3'b001:  c = CMD_REF;
            3'b000:  c = CMD_MRS;
            default: c = CMD_NOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sdc_cmd_decode.sv
`timescale 1ns/1ps
module sdc_cmd_decode
    import sdram_cb_pkg::*;
#(
    parameter int NBANK = 2
) (
    input  logic             cke,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             bank_sel,
    input  logic [NBANK-1:0] bank_active,
    output cmd_e             cmd_o,
    output logic             legal_o,
    output logic             illegal_o
);

    logic sel_open;
    logic any_open;

    always_comb begin
        // A gated clock or a deselected device yields no new command
        if (cke && !cs_n) begin
            cmd_o = strobe_to_cmd(ras_n, cas_n, we_n);
        end else begin
            cmd_o = CMD_NOP;
        end

        sel_open = bank_active[bank_sel];
        any_open = |bank_active;

        // Commands that conflict with the current bank state are rejected
        case (cmd_o)
            CMD_ACT:         illegal_o = sel_open;
            CMD_RD, CMD_WR:  illegal_o = !sel_open;
            CMD_REF, CMD_MRS: illegal_o = any_open;
            default:         illegal_o = 1'b0;
        endcase

        legal_o = (cmd_o != CMD_NOP) && !illegal_o;
    end

endmodule

// File: rtl/sdc_bank_ctl.sv
`timescale 1ns/1ps
module sdc_bank_ctl #(
    parameter int ROW_W = 11,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             act_i,
    input  logic             rdwr_i,
    input  logic             ap_i,
    input  logic             pre_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [CNT_W-1:0] bl_i,
    output logic             active_o,
    output logic [ROW_W-1:0] row_o
);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] left;   // beats until auto-close, 0 = none pending
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (en) begin
            if (pre_i) begin
                bank_d.open = 1'b0;
                bank_d.left = '0;
            end else if (act_i) begin
                bank_d.open = 1'b1;
                bank_d.row  = row_i;
                bank_d.left = '0;
            end else if (rdwr_i) begin
                // A new column access restarts or cancels the countdown
                bank_d.left = ap_i ? bl_i : '0;
            end else if (bank_q.left == CNT_W'(1)) begin
                bank_d.open = 1'b0;
                bank_d.left = '0;
            end else if (bank_q.left != '0) begin
                bank_d.left = bank_q.left - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign active_o = bank_q.open;
    assign row_o    = bank_q.row;

endmodule

// File: rtl/sdc_refresh_timer.sv
`timescale 1ns/1ps
module sdc_refresh_timer #(
    parameter int INTERVAL = 1953
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic due_o
);

    localparam int CW = $clog2(INTERVAL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          due;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clear_i) begin
            tmr_d.cnt = '0;
            tmr_d.due = 1'b0;
        end else if (!tmr_q.due) begin
            if (tmr_q.cnt == CW'(INTERVAL - 1)) begin
                tmr_d.due = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign due_o = tmr_q.due;

endmodule

// File: rtl/sdram_cmd_bank.sv
`timescale 1ns/1ps
module sdram_cmd_bank
    import sdram_cb_pkg::*;
#(
    parameter int ROW_W        = 11,
    parameter int MAX_BL_LOG   = 3,
    parameter int REF_INTERVAL = 1953
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cke,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic [ROW_W:0]        addr,
    output logic                  act_stb,
    output logic                  rd_stb,
    output logic                  wr_stb,
    output logic                  pre_stb,
    output logic                  ref_stb,
    output logic                  mrs_stb,
    output logic                  illegal_stb,
    output logic [1:0]            bank_active,
    output logic [ROW_W-1:0]      row_a,
    output logic [ROW_W-1:0]      row_b,
    output logic [MAX_BL_LOG:0]   burst_len,
    output logic [1:0]            pwr_mode
    ,
    output logic                  ref_due
);

    localparam int NBANK  = 2;
    localparam int CNT_W  = MAX_BL_LOG + 1;
    localparam int FLAG_B = ROW_W - 1;   // auto-precharge / all-bank flag
    localparam int BANK_B = ROW_W;       // bank select
    localparam int CODE_W = 3;           // burst code width in the mode word

    typedef struct packed {
        logic              act;
        logic              rd;
        logic              wr;
        logic              pre;
        logic              rfr;
        logic              mrs;
        logic              ill;
        logic [CODE_W-1:0] bl_code;
        pmode_e            pm;
    } top_t;

    top_t state_d, state_q;

    cmd_e                         cmd;
    logic                         legal;
    logic                         illegal;
    logic                         bank_sel;
    logic                         flag;
    logic                         any_open;
    logic                         ref_clear;
    logic [CODE_W-1:0]            bl_shift;
    logic [NBANK-1:0]             act_b;
    logic [NBANK-1:0]             rdwr_b;
    logic [NBANK-1:0]             pre_b;
    logic [NBANK-1:0][ROW_W-1:0]  rows;

    assign bank_sel = addr[BANK_B];
    assign flag     = addr[FLAG_B];
    assign any_open = |bank_active;

    sdc_cmd_decode #(
        .NBANK (NBANK)
    ) u_dec (
        .cke         (cke),
        .cs_n        (cs_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .bank_sel    (bank_sel),
        .bank_active (bank_active),
        .cmd_o       (cmd),
        .legal_o     (legal),
        .illegal_o   (illegal)
    );

    // Per-bank command routing and state tracking
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic hit;
        assign hit       = (bank_sel == 1'(g));
        assign act_b[g]  = legal && (cmd == CMD_ACT) && hit;
        assign rdwr_b[g] = legal && ((cmd == CMD_RD) || (cmd == CMD_WR)) && hit;
        assign pre_b[g]  = legal && (cmd == CMD_PRE) && (flag || hit);

        sdc_bank_ctl #(
            .ROW_W (ROW_W),
            .CNT_W (CNT_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (cke),
            .act_i    (act_b[g]),
            .rdwr_i   (rdwr_b[g]),
            .ap_i     (flag),
            .pre_i    (pre_b[g]),
            .row_i    (addr[ROW_W-1:0]),
            .bl_i     (burst_len),
            .active_o (bank_active[g]),
            .row_o    (rows[g])
        );
    end

    // Next-state: strobes, mode register and low-power state
    always_comb begin
        state_d     = state_q;
        state_d.act = legal && (cmd == CMD_ACT);
        state_d.rd  = legal && (cmd == CMD_RD);
        state_d.wr  = legal && (cmd == CMD_WR);
        state_d.pre = legal && (cmd == CMD_PRE);
        state_d.rfr = legal && (cmd == CMD_REF);
        state_d.mrs = legal && (cmd == CMD_MRS);
        state_d.ill = illegal;

        if (legal && (cmd == CMD_MRS)) begin
            state_d.bl_code = addr[CODE_W-1:0];
        end

        if (cke) begin
            state_d.pm = PM_RUN;
        end else if (state_q.pm == PM_SELF) begin
            state_d.pm = PM_SELF;
        end else if (!cs_n && (strobe_to_cmd(ras_n, cas_n, we_n) == CMD_REF) && !any_open) begin
            state_d.pm = PM_SELF;
        end else if (any_open) begin
            state_d.pm = PM_SUSP;
        end else begin
            state_d.pm = PM_PDOWN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Burst length from the stored code, saturating at the longest burst
    always_comb begin
        if (state_q.bl_code > CODE_W'(MAX_BL_LOG)) begin
            bl_shift = CODE_W'(MAX_BL_LOG);
        end else begin
            bl_shift = state_q.bl_code;
        end
        burst_len = CNT_W'(1) << bl_shift;
    end

    assign ref_clear = state_d.rfr || (state_d.pm == PM_SELF);

    sdc_refresh_timer #(
        .INTERVAL (REF_INTERVAL)
    ) u_rtmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (ref_clear),
        .due_o   (ref_due)
    );

    assign act_stb     = state_q.act;
    assign rd_stb      = state_q.rd;
    assign wr_stb      = state_q.wr;
    assign pre_stb     = state_q.pre;
    assign ref_stb     = state_q.rfr;
    assign mrs_stb     = state_q.mrs;
    assign illegal_stb = state_q.ill;
    assign row_a       = rows[0];
    assign row_b       = rows[1];
    assign pwr_mode    = state_q.pm;

endmodule

// File: rtl/sdram_cmd_bank_chk.sv
`timescale 1ns/1ps
module sdram_cmd_bank_chk #(
    parameter int ROW_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cke,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [ROW_W:0]   addr,
    input logic             act_stb,
    input logic             rd_stb,
    input logic             wr_stb,
    input logic             pre_stb,
    input logic             ref_stb,
    input logic             mrs_stb,
    input logic             illegal_stb,
    input logic [1:0]       bank_active,
    input logic [ROW_W-1:0] row_a,
    input logic [ROW_W-1:0] row_b,
    input logic [1:0]       pwr_mode
);

    logic [6:0] stb;
    logic [2:0] enc;
    assign stb = {act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mrs_stb, illegal_stb};
    assign enc = {ras_n, cas_n, we_n};

    // R2: at most one strobe at a time
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));

    // R1: deselect produces no strobe
    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (stb == 7'd0));

    // R10: gated clock freezes bank state and suppresses strobes
    a_r10_gated_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (stb == 7'd0) && $stable(bank_active) && $stable(row_a) && $stable(row_b));

    // R11: clock enable high returns to run mode
    a_r11_run_on_cke: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> (pwr_mode == 2'd0));

    // R4: activate to an open bank is rejected
    a_r4_act_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && enc == 3'b011 && bank_active[addr[ROW_W]]) |=> illegal_stb && !act_stb);

    // R5: column access to an idle bank is rejected
    a_r5_rw_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && (enc == 3'b101 || enc == 3'b100) && !bank_active[addr[ROW_W]])
        |=> illegal_stb && !rd_stb && !wr_stb);

    // R7: precharge with the flag set closes both banks
    a_r7_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && enc == 3'b010 && addr[ROW_W-1]) |=> (bank_active == 2'b00));

endmodule

bind sdram_cmd_bank sdram_cmd_bank_chk #(.ROW_W(ROW_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke         (cke),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .addr        (addr),
    .act_stb     (act_stb),
    .rd_stb      (rd_stb),
    .wr_stb      (wr_stb),
    .pre_stb     (pre_stb),
    .ref_stb     (ref_stb),
    .mrs_stb     (mrs_stb),
    .illegal_stb (illegal_stb),
    .bank_active (bank_active),
    .row_a       (row_a),
    .row_b       (row_b),
    .pwr_mode    (pwr_mode)
);

// File: tb/sdram_cmd_bank_tb.sv
`timescale 1ns/1ps
module sdram_cmd_bank_tb;

    localparam int RI = 60;

    localparam logic [2:0] E_ACT = 3'b011;
    localparam logic [2:0] E_RD  = 3'b101;
    localparam logic [2:0] E_WR  = 3'b100;
    localparam logic [2:0] E_PRE = 3'b010;
    localparam logic [2:0] E_REF = 3'b001;
    localparam logic [2:0] E_MRS = 3'b000;
    localparam logic [2:0] E_NOP = 3'b111;

    // strobe vector order: {act, rd, wr, pre, ref, mrs, illegal}
    localparam logic [6:0] S_NONE = 7'b0000000;
    localparam logic [6:0] S_ACT  = 7'b1000000;
    localparam logic [6:0] S_RD   = 7'b0100000;
    localparam logic [6:0] S_WR   = 7'b0010000;
    localparam logic [6:0] S_PRE  = 7'b0001000;
    localparam logic [6:0] S_REF  = 7'b0000100;
    localparam logic [6:0] S_MRS  = 7'b0000010;
    localparam logic [6:0] S_ILL  = 7'b0000001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b0;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [11:0] addr = '0;
    logic        act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mrs_stb, illegal_stb;
    logic [1:0]  bank_active;
    logic [10:0] row_a, row_b;
    logic [3:0]  burst_len;
    logic [1:0]  pwr_mode;
    logic        ref_due;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sdram_cmd_bank #(.REF_INTERVAL(RI)) u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
        .act_stb(act_stb), .rd_stb(rd_stb), .wr_stb(wr_stb), .pre_stb(pre_stb),
        .ref_stb(ref_stb), .mrs_stb(mrs_stb), .illegal_stb(illegal_stb),
        .bank_active(bank_active), .row_a(row_a), .row_b(row_b),
        .burst_len(burst_len), .pwr_mode(pwr_mode), .ref_due(ref_due)
    );

    function automatic logic [6:0] stb();
        return {act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mrs_stb, illegal_stb};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock edge: drive at the falling edge, settle just after the rising edge
    task automatic step(input logic k, input logic s, input logic [2:0] e, input logic [11:0] a);
        @(negedge clk);
        cke = k; cs_n = s; {ras_n, cas_n, we_n} = e; addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();
        step(1'b1, 1'b0, E_NOP, 12'h000);
    endtask

    task automatic t_reset();
        chk("R13", "strobes", 32'(stb()), 32'(S_NONE));
        chk("R13", "bank_active", 32'(bank_active), 32'd0);
        chk("R13", "burst_len", 32'(burst_len), 32'd1);
        chk("R13", "pwr_mode", 32'(pwr_mode), 32'd0);
        chk("R13", "ref_due", 32'(ref_due), 32'd0);
    endtask

    task automatic t_mode();
        step(1, 0, E_MRS, 12'h002);
        chk("R2", "mrs strobe", 32'(stb()), 32'(S_MRS));
        chk("R8", "code 2", 32'(burst_len), 32'd4);
        step(1, 0, E_MRS, 12'h006);
        chk("R8", "code 6", 32'(burst_len), 32'd8);
        step(1, 0, E_MRS, 12'h001);
        chk("R8", "code 1", 32'(burst_len), 32'd2);
        step(1, 0, E_MRS, 12'h002);
        nop();
        chk("R2", "strobe one cycle", 32'(stb()), 32'(S_NONE));
    endtask

    task automatic t_activate();
        step(1, 0, E_ACT, {1'b0, 11'h2A5});
        chk("R2", "act strobe", 32'(stb()), 32'(S_ACT));
        chk("R3", "bank A open", 32'(bank_active), 32'b01);
        chk("R3", "row_a", 32'(row_a), 32'h2A5);
        step(1, 0, E_ACT, {1'b1, 11'h13C});
        chk("R3", "both open", 32'(bank_active), 32'b11);
        chk("R3", "row_b", 32'(row_b), 32'h13C);
        step(1, 0, E_ACT, {1'b0, 11'h111});
        chk("R4", "act to open bank", 32'(stb()), 32'(S_ILL));
        chk("R4", "row_a kept", 32'(row_a), 32'h2A5);
        step(1, 0, E_MRS, 12'h000);
        chk("R8", "mrs while open", 32'(stb()), 32'(S_ILL));
        chk("R8", "burst kept", 32'(burst_len), 32'd4);
        step(1, 0, E_REF, 12'h000);
        chk("R9", "refresh while open", 32'(stb()), 32'(S_ILL));
    endtask

    task automatic t_rw_open();
        step(1, 0, E_RD, {1'b0, 1'b0, 10'h010});
        chk("R2", "read strobe", 32'(stb()), 32'(S_RD));
        for (int i = 0; i < 6; i++) nop();
        chk("R6", "no auto close", 32'(bank_active), 32'b11);
        step(1, 0, E_WR, {1'b1, 1'b0, 10'h020});
        chk("R2", "write strobe", 32'(stb()), 32'(S_WR));
        chk("R6", "write keeps open", 32'(bank_active), 32'b11);
    endtask

    task automatic t_precharge();
        step(1, 0, E_PRE, {1'b1, 1'b0, 10'h000});
        chk("R2", "pre strobe", 32'(stb()), 32'(S_PRE));
        chk("R7", "single bank B", 32'(bank_active), 32'b01);
        chk("R7", "row_a intact", 32'(row_a), 32'h2A5);
        step(1, 0, E_ACT, {1'b1, 11'h13C});
        step(1, 0, E_PRE, {1'b1, 1'b1, 10'h000});
        chk("R7", "all banks", 32'(bank_active), 32'b00);
    endtask

    task automatic t_idle_rw();
        step(1, 0, E_RD, {1'b0, 1'b0, 10'h000});
        chk("R5", "read idle", 32'(stb()), 32'(S_ILL));
        chk("R5", "stays idle", 32'(bank_active), 32'b00);
        step(1, 0, E_WR, {1'b1, 1'b1, 10'h000});
        chk("R5", "write idle", 32'(stb()), 32'(S_ILL));
        chk("R5", "still idle", 32'(bank_active), 32'b00);
    endtask

    task automatic t_autopre();
        step(1, 0, E_ACT, {1'b0, 11'h055});
        step(1, 0, E_RD, {1'b0, 1'b1, 10'h000});   // burst length 4
        for (int i = 0; i < 3; i++) begin
            nop();
            chk("R6", "open before burst end", 32'(bank_active[0]), 32'd1);
        end
        nop();
        chk("R6", "closed at burst end", 32'(bank_active[0]), 32'd0);
        step(1, 0, E_MRS, 12'h000);                 // burst length 1
        step(1, 0, E_ACT, {1'b1, 11'h077});
        step(1, 0, E_WR, {1'b1, 1'b1, 10'h000});
        chk("R6", "bl1 open on command", 32'(bank_active), 32'b10);
        nop();
        chk("R6", "bl1 closed next edge", 32'(bank_active), 32'b00);
        step(1, 0, E_MRS, 12'h002);
    endtask

    task automatic t_cs_hold();
        step(1, 0, E_ACT, {1'b0, 11'h0AA});
        step(1, 0, E_RD, {1'b0, 1'b1, 10'h000});
        for (int i = 0; i < 3; i++) begin
            step(1, 1, E_ACT, {1'b1, 11'h3FF});
            chk("R1", "no strobe", 32'(stb()), 32'(S_NONE));
            chk("R1", "bank B not opened", 32'(bank_active), 32'b01);
        end
        step(1, 1, E_ACT, {1'b1, 11'h3FF});
        chk("R1", "countdown continued", 32'(bank_active), 32'b00);
    endtask

    task automatic t_cke_freeze();
        step(1, 0, E_ACT, {1'b0, 11'h0F0});
        step(1, 0, E_RD, {1'b0, 1'b1, 10'h000});
        for (int i = 0; i < 3; i++) begin
            step(0, 0, E_ACT, {1'b1, 11'h005});
            chk("R10", "no strobe", 32'(stb()), 32'(S_NONE));
            chk("R10", "suspend", 32'(pwr_mode), 32'd2);
            chk("R10", "frozen open", 32'(bank_active), 32'b01);
        end
        chk("R10", "row_b frozen", 32'(row_b), 32'h077);
        for (int i = 0; i < 3; i++) begin
            nop();
            chk("R10", "countdown resumed", 32'(bank_active), 32'b01);
        end
        chk("R11", "run mode", 32'(pwr_mode), 32'd0);
        nop();
        chk("R10", "closed after resume", 32'(bank_active), 32'b00);
        step(0, 0, E_NOP, 12'h000);
        chk("R10", "power-down", 32'(pwr_mode), 32'd1);
        nop();
    endtask

    task automatic t_selfref();
        step(0, 0, E_REF, 12'h000);
        chk("R11", "enter self refresh", 32'(pwr_mode), 32'd3);
        chk("R11", "no strobe", 32'(stb()), 32'(S_NONE));
        chk("R12", "due cleared", 32'(ref_due), 32'd0);
        step(0, 0, E_NOP, 12'h000);
        step(0, 1, E_NOP, 12'h000);
        chk("R11", "held", 32'(pwr_mode), 32'd3);
        nop();
        chk("R11", "exit", 32'(pwr_mode), 32'd0);
    endtask

    task automatic t_ref_due();
        step(1, 0, E_REF, 12'h000);
        chk("R2", "refresh strobe", 32'(stb()), 32'(S_REF));
        chk("R12", "cleared by refresh", 32'(ref_due), 32'd0);
        for (int i = 0; i < RI - 1; i++) nop();
        chk("R12", "one edge early", 32'(ref_due), 32'd0);
        nop();
        chk("R12", "raised on time", 32'(ref_due), 32'd1);
        step(1, 0, E_REF, 12'h000);
        chk("R12", "cleared again", 32'(ref_due), 32'd0);
    endtask

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_mode();
        t_activate();
        t_rw_open();
        t_precharge();
        t_idle_rw();
        t_autopre();
        t_cs_hold();
        t_cke_freeze();
        t_selfref();
        t_ref_due();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule